// File: doc/BRIEF.md
# Most-significant-first signed-digit recoder

This block turns an unsigned binary operand into a signed-digit string with digits from {-1, 0, +1}. The string has the same value as the operand and as few nonzero digits as the non-adjacent form. The digits come out one per clock cycle, starting at the most significant position. A serial multiplier that scans its multiplier from the top can therefore use each digit as soon as it appears, and it adds or subtracts only where a digit is nonzero.

Each step of the walk looks at a three-bit window of the operand: the current bit and the two bits below it. It also uses a one-bit chain flag, which records whether a run of ones is being absorbed. From these the step emits one digit and the next flag. The operand is extended by a zero above its top bit and two zeros below bit 0. The flag starts at zero, so an operand of WIDTH bits yields WIDTH+1 digits, for positions WIDTH down to 0. A window and flag pair that legal operation can never produce sets a sticky error output.

Top module: `msb_sd_recoder`

## Requirements
- R1: After reset, `valid_o`, `last_o`, `busy_o` and `err_o` are all 0, and `digit_o` is 2'b00.
- R2: When `start_i` is high at a clock edge while `busy_o` is low, `operand_i` is captured. From the next cycle on, `valid_o` stays high for exactly WIDTH+1 consecutive cycles. The digits arrive for positions WIDTH, WIDTH-1, ..., 0 in that order.
- R3: `last_o` is high only in the cycle that carries the digit for position 0. In the cycle after it, `valid_o` and `busy_o` are low.
- R4: Digit codes are 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. Code 2'b10 never appears, and `digit_o` is 2'b00 whenever `valid_o` is low.
- R5: The sum over all positions i of digit(i)·2^i equals the captured operand.
- R6: The number of nonzero digits equals the nonzero count of the operand's non-adjacent form.
- R7: A run of ones at positions h..l, with zeros on both sides, recodes to +1 at position h+1 and -1 at position l, with zeros in between. For example, 7 gives +1 at position 3 and -1 at position 0.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The digit stream in progress continues unchanged.
- R9: `err_o` goes high and stays high until reset if a step ever sees flag 0 with window 11x, or flag 1 with window 00x. In legal operation it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture `operand_i` and begin recoding when idle |
| operand_i | input | WIDTH | Unsigned operand |
| digit_o | output | 2 | Signed digit code (00=0, 01=+1, 11=-1) |
| valid_o | output | 1 | `digit_o` holds a digit this cycle |
| last_o | output | 1 | Current digit is position 0 |
| busy_o | output | 1 | Recoding in progress; a start is ignored |
| err_o | output | 1 | Sticky: unreachable window/flag pair seen |

## Verification
The assertions assume that the chain flag is cleared at every accepted start and that `start_i` is a synchronous, glitch-free level. Under those assumptions the error flag never rises and every valid run spans exactly WIDTH+1 cycles. The stimulus drives `start_i` and `operand_i` only on falling edges. It holds the pulse for a single clock and deliberately repeats it during a run to exercise the ignored-start path. The operands cover all-zero, all-one, alternating, isolated-run and pseudo-random patterns, so every legal window/flag pair in the lookup is visited.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_NEG  = 2'b11
    } sd_digit_e;
endpackage

// File: rtl/sdr_digit_lut.sv
// One recoding step: window {b_i, b_i-1, b_i-2} plus chain flag -> digit, next flag.
module sdr_digit_lut
    import sdr_pkg::*;
(
    input  logic       flag_i,
    input  logic [2:0] win_i,
    output sd_digit_e  digit_o,
    output logic       flag_o,
    output logic       illegal_o
);
    always_comb begin
        digit_o   = DIG_ZERO;
        flag_o    = flag_i;
        illegal_o = 1'b0;
        if (!flag_i) begin
            unique casez (win_i)
                3'b00?: begin digit_o = DIG_ZERO; flag_o = 1'b0; end
                3'b010: begin digit_o = DIG_ZERO; flag_o = 1'b0; end
                3'b011: begin digit_o = DIG_POS;  flag_o = 1'b1; end
                3'b10?: begin digit_o = DIG_POS;  flag_o = 1'b0; end
                default: begin digit_o = DIG_ZERO; flag_o = 1'b0; illegal_o = 1'b1; end
            endcase
        end else begin
            unique casez (win_i)
                3'b11?: begin digit_o = DIG_ZERO; flag_o = 1'b1; end
                3'b101: begin digit_o = DIG_ZERO; flag_o = 1'b1; end
                3'b100: begin digit_o = DIG_NEG;  flag_o = 1'b0; end
                3'b01?: begin digit_o = DIG_NEG;  flag_o = 1'b1; end
                default: begin digit_o = DIG_ZERO; flag_o = 1'b1; illegal_o = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/sdr_step_counter.sv
// Counts the remaining digit positions of a run; flags the final one.
module sdr_step_counter #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic final_o
);
    localparam int CW = $clog2(STEPS + 1);
    localparam logic [CW-1:0] TOP = CW'(STEPS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = TOP;
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign final_o = (cnt_q == '0);
endmodule

// File: rtl/msb_sd_recoder.sv
module msb_sd_recoder
    import sdr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] operand_i,
    output logic [1:0]       digit_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             err_o
);
    localparam int SRW = WIDTH + 3;   // leading zero + operand + two trailing zeros

    typedef struct packed {
        logic           busy;
        logic           flag;
        logic           err;
        logic [SRW-1:0] win;
    } state_t;

    state_t    st_d, st_q;
    sd_digit_e lut_digit;
    logic      lut_flag, lut_illegal, cnt_final, accept;

    assign accept = start_i && !st_q.busy;

    sdr_digit_lut i_lut (
        .flag_i    (st_q.flag),
        .win_i     (st_q.win[SRW-1 -: 3]),
        .digit_o   (lut_digit),
        .flag_o    (lut_flag),
        .illegal_o (lut_illegal)
    );

    sdr_step_counter #(.STEPS(WIDTH)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .run_i   (st_q.busy),
        .final_o (cnt_final)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.flag = 1'b0;
            st_d.win  = {1'b0, operand_i, 2'b00};
        end else if (st_q.busy) begin
            st_d.flag = lut_flag;
            st_d.win  = {st_q.win[SRW-2:0], 1'b0};
            st_d.err  = st_q.err | lut_illegal;
            if (cnt_final) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign digit_o = st_q.busy ? lut_digit : DIG_ZERO;
    assign valid_o = st_q.busy;
    assign last_o  = st_q.busy && cnt_final;
    assign busy_o  = st_q.busy;
    assign err_o   = st_q.err;
endmodule

// File: rtl/sdr_checker.sv
module sdr_checker #(
    parameter int WIDTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] digit_o,
    input logic       valid_o,
    input logic       last_o,
    input logic       busy_o,
    input logic       err_o
);
    localparam int RW = $clog2(WIDTH + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (valid_o) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !valid_o && !err_o); // R1
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> valid_o); // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> run_q == RW'(WIDTH)); // R2
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o && !busy_o); // R3
    AST_LAST_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R3
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        digit_o != 2'b10); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> digit_o == 2'b00); // R4
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> valid_o); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o); // R9
endmodule

bind msb_sd_recoder sdr_checker #(.WIDTH(WIDTH)) i_sdr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .digit_o (digit_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .busy_o  (busy_o),
    .err_o   (err_o)
);

// File: tb/test_msb_sd_recoder.sv
`timescale 1ns/1ps
module test_msb_sd_recoder;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [WIDTH-1:0] operand_i = '0;
    logic [1:0]       digit_o;
    logic             valid_o, last_o, busy_o, err_o;

    int checks = 0;
    int errors = 0;
    int got_digit [0:WIDTH];

    always #4 clk = ~clk;   // 125 MHz

    msb_sd_recoder #(.WIDTH(WIDTH)) i_msb_sd_recoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .digit_o(digit_o), .valid_o(valid_o), .last_o(last_o),
        .busy_o(busy_o), .err_o(err_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int naf_weight(input longint v);
        int w = 0;
        longint x = v;
        while (x != 0) begin
            if (x[0]) begin
                w++;
                if (x[1]) x = x + 1; else x = x - 1;
            end
            x = x >>> 1;
        end
        return w;
    endfunction

    // Runs one recoding; optional restart pulse at digit index poke_at (-1 = none).
    task automatic run_case(input logic [WIDTH-1:0] val, input int poke_at);
        longint sum = 0;
        int     wt = 0;
        int     dv;
        @(negedge clk);
        operand_i = val;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        for (int k = 0; k <= WIDTH; k++) begin
            check("R2 valid in run", valid_o, 1);
            check("R4 code not 10", (digit_o == 2'b10), 0);
            check("R3 last position", last_o, (k == WIDTH));
            dv = (digit_o == 2'b01) ? 1 : (digit_o == 2'b11) ? -1 : 0;
            got_digit[WIDTH - k] = dv;
            sum += longint'(dv) <<< (WIDTH - k);
            if (dv != 0) wt++;
            if (k == poke_at) begin
                operand_i = ~val;
                start_i   = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        check("R3 valid drops", valid_o, 0);
        check("R3 busy drops", busy_o, 0);
        check("R4 idle digit", digit_o, 0);
        check(poke_at >= 0 ? "R8 value despite restart" : "R5 value", sum, longint'(val));
        check("R6 weight", wt, naf_weight(longint'(val)));
        check("R9 no error", err_o, 0);
    endtask

    task automatic t_reset();
        check("R1 valid", valid_o, 0);
        check("R1 last", last_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 err", err_o, 0);
        check("R1 digit", digit_o, 0);
    endtask

    task automatic t_run_of_ones();
        run_case(16'h0007, -1);
        for (int p = 0; p <= WIDTH; p++)
            check($sformatf("R7 pos %0d of 7", p), got_digit[p],
                  (p == 3) ? 1 : (p == 0) ? -1 : 0);
        run_case(16'h0F00, -1);
        for (int p = 0; p <= WIDTH; p++)
            check($sformatf("R7 pos %0d of 0F00", p), got_digit[p],
                  (p == 12) ? 1 : (p == 8) ? -1 : 0);
    endtask

    task automatic t_edges();
        run_case(16'h0000, -1);
        run_case(16'hFFFF, -1);
        check("R7 top of FFFF", got_digit[WIDTH], 1);
        run_case(16'h5555, -1);
        run_case(16'hAAAA, -1);
        run_case(16'h8001, -1);
        run_case(16'hB6DB, -1);
    endtask

    task automatic t_restart_ignored();
        run_case(16'h1234, 3);
        run_case(16'h6DB7, WIDTH);   // pulse during the last digit
    endtask

    task automatic t_random();
        logic [WIDTH-1:0] lfsr = 16'hACE1;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_case(lfsr, -1);
        end
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_of_ones();
        t_edges();
        t_restart_ignored();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule